// File: doc/BRIEF.md
# Fixed-Period Register-Programmed PWM Generator

This block makes one pulse-width-modulated output whose period never changes. The period is split into 256 equal steps. A prescaler divides the system clock into a one-clock step tick, and an 8-bit step counter advances on each tick, running freely from reset onward. A host programs the block through a byte-wide register port that has a write strobe, an address, write data and combinational read data.

The duty register sets the high time as (value + 1) steps. A register value of 0 therefore gives one step and 255 gives a constant high level, so 0% cannot be produced with the output enabled. A low level is reached by clearing the enable bit. That releases the pin driver and leaves an external pull-down to hold the line low.

Register writes act on the next clock, in the middle of the current period. There is no shadow copy, so a short irregular pulse is accepted in the period where a change is made. The step counter runs whether the output is enabled or not.

Top module: `fixed_period_pwm`

## Requirements
- R1: While rst_ni is low, both registers read 0x00, pwm_oe_o is 0 and pwm_o is 0.
- R2: The step counter advances by one once every CLKS_PER_STEP clocks, counted from the release of reset.
- R3: The step counter wraps from 255 to 0. It runs continuously whatever the enable bit and the duty value are.
- R4: While enabled, pwm_o is 1 when the step count is less than or equal to the duty value and 0 otherwise. A duty of 0xFF gives a constant high and a duty of 0x00 gives one step.
- R5: Enable is bit 7 of the control register at address 0xD2. pwm_oe_o equals that bit. When the bit is 0, pwm_o is 0.
- R6: Bits 6..0 of the control register at 0xD2 are stored and read back unchanged, and they have no effect on the output.
- R7: The duty register at address 0xD8 holds 8 bits and reads back the value last written.
- R8: A write to either register changes the output from the clock edge that samples the write, even in the middle of a period.
- R9: Reads from any address other than 0xD2 and 0xD8 return 0x00, and writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| pwm_o | output | 1 | PWM level |
| pwm_oe_o | output | 1 | Pin driver enable; 0 releases the pin |

## Verification
A behavioural model of the step counter and the registers predicts the output level, the driver enable and the read data on every clock. The duty is tried at a middle value, at the two extremes 0x00 and 0xFF, and with changes written in the middle of a period. These cases separate a correct less-than-or-equal compare from an off-by-one compare, and immediate updates from updates deferred to the period boundary. Disabling and re-enabling the output without a reset shows that the counter kept running, because the phase after re-enable must match the model. Writes to unused addresses, and control writes with varied low bits, show that neither disturbs the output or the stored values.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned STEP_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'hD2;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 8'hD8;
  localparam int unsigned EN_BIT = 7;
endpackage

// File: rtl/pwm_step_prescaler.sv
module pwm_step_prescaler #(
  parameter int unsigned CLKS_PER_STEP = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLKS_PER_STEP <= 1) begin : g_pass
      assign tick_o = rst_ni;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLKS_PER_STEP);
      localparam logic [CW-1:0] LAST = CW'(CLKS_PER_STEP - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_q;
  // natural wrap at 2**STEP_W - 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (tick_i) step_q <= step_q + 1'b1;
  end
  assign step_o = step_q;
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] duty_o
);
  logic [DATA_W-1:0] ctrl_q, duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i;
      if (addr_i == ADDR_DUTY) duty_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_DUTY: rdata_o = duty_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign duty_o = duty_q;
endmodule

// File: rtl/fixed_period_pwm.sv
module fixed_period_pwm
  import pwm_pkg::*;
#(
  parameter int unsigned CLKS_PER_STEP = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       pwm_o,
  output logic       pwm_oe_o
);
  logic              step_tick;
  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] ctrl_q, duty_q;
  logic              out_en;

  pwm_step_prescaler #(.CLKS_PER_STEP(CLKS_PER_STEP)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(step_tick)
  );

  pwm_step_counter u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(step_tick),
    .step_o(step_q)
  );

  pwm_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctrl_o (ctrl_q),
    .duty_o (duty_q)
  );

  assign out_en   = ctrl_q[EN_BIT];
  assign pwm_oe_o = out_en;
  // duty code n gives n+1 high steps
  assign pwm_o    = out_en && (step_q <= STEP_W'(duty_q));
endmodule

// File: rtl/fixed_period_pwm_chk.sv
module fixed_period_pwm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       step_tick,
  input logic [7:0] step_q,
  input logic [7:0] ctrl_q,
  input logic [7:0] duty_q,
  input logic       pwm_o,
  input logic       pwm_oe_o
);
  p_step_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_tick |=> $stable(step_q));
  p_step_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_tick && step_q == 8'hFF) |=> step_q == 8'h00);
  p_full_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_oe_o && duty_q == 8'hFF) |-> pwm_o);
  p_pwm_needs_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> pwm_oe_o);
  p_oe_tracks_ctrl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 8'hD2) |=> pwm_oe_o == $past(reg_wdata_i[7]));
  p_duty_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 8'hD8) |=> duty_q == $past(reg_wdata_i));
  p_ctrl_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i != 8'hD2) |=> $stable(ctrl_q));
endmodule

bind fixed_period_pwm fixed_period_pwm_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .step_tick  (step_tick),
  .step_q     (step_q),
  .ctrl_q     (ctrl_q),
  .duty_q     (duty_q),
  .pwm_o      (pwm_o),
  .pwm_oe_o   (pwm_oe_o)
);

// File: tb/fixed_period_pwm_tb.sv
module fixed_period_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPS = 3;
  localparam int WATCHDOG = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       pwm_o, pwm_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  int m_pc = 0, m_step = 0, m_ctrl = 0, m_duty = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fixed_period_pwm #(.CLKS_PER_STEP(CPS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = 0; m_step = 0; m_ctrl = 0; m_duty = 0;
    end else begin
      if (reg_we_i && reg_addr_i == 8'hD2) m_ctrl = reg_wdata_i;
      if (reg_we_i && reg_addr_i == 8'hD8) m_duty = reg_wdata_i;
      if (m_pc == CPS-1) begin
        m_pc = 0;
        m_step = (m_step + 1) % 256;
      end else m_pc = m_pc + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk_i) begin
    if (!done) begin
      int en, epwm, erd;
      en   = (m_ctrl >> 7) & 1;
      epwm = en && (m_step <= m_duty);
      erd  = (reg_addr_i == 8'hD2) ? m_ctrl : (reg_addr_i == 8'hD8) ? m_duty : 0;
      if (!rst_ni) begin
        check(pwm_oe_o == 0 && pwm_o == 0 && reg_rdata_o == 0, "R1", {pwm_oe_o, pwm_o, reg_rdata_o}, 0);
      end else begin
        check(pwm_o == epwm, "R4/R2/R3/R8 pwm", pwm_o, epwm);
        check(pwm_oe_o == en, "R5 oe", pwm_oe_o, en);
        if (reg_addr_i == 8'hD2)      check(reg_rdata_o == erd, "R6 ctrl read", reg_rdata_o, erd);
        else if (reg_addr_i == 8'hD8) check(reg_rdata_o == erd, "R7 duty read", reg_rdata_o, erd);
        else                          check(reg_rdata_o == 0, "R9 unused read", reg_rdata_o, 0);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk_i); #1;
    reg_addr_i = a;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    run(4);
    rd(8'hD8);
    run(2);
    rst_ni = 1'b1;
    // R1 explicit read-back after reset
    rd(8'hD2); run(2);
    // R7 mid duty, R5 enable with R6 low bits
    wr(8'hD8, 8'h40);
    wr(8'hD2, 8'h95);
    run(2 * 256 * CPS);
    // R4 extremes
    wr(8'hD8, 8'h00);
    run(256 * CPS + 50);
    wr(8'hD8, 8'hFF);
    run(256 * CPS);
    // R8 mid-period changes
    run(100 * CPS);
    wr(8'hD8, 8'h20);
    run(30 * CPS);
    wr(8'hD8, 8'hC0);
    run(256 * CPS);
    // R3 disable, counter keeps running; R6 low bits only
    wr(8'hD2, 8'h2A);
    rd(8'hD2);
    run(300 * CPS + 1);
    wr(8'hD2, 8'h80);
    run(256 * CPS);
    // R9 writes to unused addresses
    wr(8'h10, 8'hAA);
    wr(8'hD3, 8'h00);
    wr(8'hD9, 8'h11);
    rd(8'h10); run(3);
    rd(8'hD8); run(3);
    rd(8'hD2); run(256 * CPS);
    finish_up();
  end
endmodule